// File: doc/BRIEF.md
# Programmable TCK Rate Generator

This block turns a requested test-clock frequency into the number of timer cycles that make up half a TCK period. It then paces a shift engine by answering each half-period wait with a single tick. The timer frequency is a fixed parameter. A request carries a 32-bit frequency in hertz. Dividing the timer frequency by that value uses an iterative restoring divider that takes several cycles. While it runs, the block reports busy and ignores further requests. When it finishes, it returns a one-byte status.

The divider quotient is halved, and then a fixed software overhead (50 cycles by default) is removed, with the result held at no less than zero. A result that does not fit a signed 16-bit countdown is refused. A refused request, including a request for zero hertz, leaves the previous setting in place. Out of reset the setting is the value derived for 100 kHz, using the same halving and overhead rule.

For a half-period wait, the block adds the current setting to a free-running 16-bit counter to form a target. It raises its tick when the signed 16-bit difference between the counter and the target stops being negative. This comparison stays correct when the counter wraps.

Top module: `tck_rate_gen`

## Requirements
- R1: After reset, `half_count` equals floor(floor(TIMER_HZ/DEFAULT_HZ)/2) minus OVERHEAD, held at no less than 0. This is 190 with the defaults. `rate_busy`, `rate_status_valid` and `half_tick` are 0.
- R2: A request for 0 Hz that is accepted while idle raises `rate_status_valid` on the next cycle with `rate_status` = 8'hFF. `rate_busy` does not rise and `half_count` does not change.
- R3: A nonzero request that is accepted while idle sets `rate_busy` high on the next cycle and keeps it high for 33 cycles. In the cycle where `rate_busy` falls, `rate_status_valid` is high for exactly one cycle.
- R4: For a nonzero frequency f, the new setting is h = floor(floor(TIMER_HZ/f)/2). If h ≤ OVERHEAD the setting is 0; otherwise it is h − OVERHEAD. An accepted setting appears on `half_count` in the same cycle as its status, and that status is 8'h00.
- R5: If the corrected value is 0x8000 or more, the status is 8'hFF and `half_count` keeps its previous value.
- R6: A request presented while `rate_busy` is high is ignored. The status and setting that follow are those of the request already in progress, and no extra status pulse occurs.
- R7: If `wait_req` is raised in cycle t while no wait is pending, `half_tick` is high in cycle t + `half_count`. When `half_count` is 0, `half_tick` is high in every cycle in which `wait_req` is high.
- R8: While a wait is pending, `wait_req` is ignored, and the pending wait still ends at its original target.
- R9: Waits of up to 0x7FFF cycles end on time even when the 16-bit counter wraps during the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_req_valid | input | 1 | Request strobe; taken only when not busy |
| rate_req_hz | input | 32 | Requested TCK frequency in Hz |
| rate_busy | output | 1 | Divider in progress; requests are ignored |
| rate_status_valid | output | 1 | One-cycle pulse that marks a valid status |
| rate_status | output | 8 | 8'h00 accepted, 8'hFF refused |
| half_count | output | 16 | Current half-period setting in timer cycles |
| wait_req | input | 1 | Starts a half-period wait |
| half_tick | output | 1 | End of the half-period wait |

## Verification
The bench targets the overhead floor. It drives a frequency whose halved quotient is exactly 50, which must give 0, and another that gives 51, which must give 1. A design that compares with the wrong sense would return 0 or a wrapped value near 0xFFFF. It also drives requests on both sides of the 0x8000 limit, a zero request, and a request during busy. A design that wrote the setting before checking the range, or that took the second request, would show a changed `half_count`. On the timer side, the bench drives zero-length waits that must tick in the same cycle, a repeated `wait_req` during a pending wait, and waits of about 0x7FE0 cycles that span a counter wrap. An unsigned compare in the timer would end those waits early or late.

// File: rtl/tck_rate_pkg.sv
package tck_rate_pkg;

  localparam int unsigned HZ_W = 32;

  typedef enum logic [7:0] {
    RATE_OK  = 8'h00,
    RATE_ERR = 8'hFF
  } rate_status_e;

  // Halve a full-period quotient, then remove the fixed overhead, floored at 0.
  function automatic logic [HZ_W-1:0] half_period_of(
    input logic [HZ_W-1:0] quotient,
    input logic [HZ_W-1:0] overhead
  );
    logic [HZ_W-1:0] half;
    half = quotient >> 1;
    if (half <= overhead) return '0;
    return half - overhead;
  endfunction

endpackage

// File: rtl/tck_rate_div.sv
module tck_rate_div #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         fin,
  output logic [W-1:0] quotient
);
  localparam int unsigned STEP_W = $clog2(W + 1);

  logic [W-1:0]      rem_q;
  logic [W-1:0]      dvd_q;
  logic [W-1:0]      dsr_q;
  logic [STEP_W-1:0] steps_q;
  logic              running;
  logic [W:0]        trial;
  logic [W:0]        diff;
  logic              fits;

  assign trial = {rem_q, dvd_q[W-1]};
  assign diff  = trial - {1'b0, dsr_q};
  assign fits  = trial >= {1'b0, dsr_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      dvd_q    <= '0;
      dsr_q    <= '0;
      steps_q  <= '0;
      running  <= 1'b0;
      fin      <= 1'b0;
      quotient <= '0;
    end else begin
      fin <= 1'b0;
      if (start && !running) begin
        rem_q    <= '0;
        dvd_q    <= dividend;
        dsr_q    <= divisor;
        quotient <= '0;
        steps_q  <= STEP_W'(W);
        running  <= 1'b1;
      end else if (running) begin
        rem_q    <= fits ? diff[W-1:0] : trial[W-1:0];
        dvd_q    <= dvd_q << 1;
        quotient <= {quotient[W-2:0], fits};
        steps_q  <= steps_q - 1'b1;
        if (steps_q == STEP_W'(1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tck_rate_ctrl.sv
module tck_rate_ctrl
  import tck_rate_pkg::*;
#(
  parameter int unsigned TIMER_HZ   = 48_000_000,
  parameter int unsigned DEFAULT_HZ = 100_000,
  parameter int unsigned OVERHEAD   = 50,
  parameter int unsigned CNT_W      = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [HZ_W-1:0] req_hz,
  input  logic            div_fin,
  input  logic [HZ_W-1:0] div_quotient,
  output logic            div_start,
  output logic            busy,
  output logic            status_valid,
  output logic [7:0]      status,
  output logic [CNT_W-1:0] half_count
);
  localparam logic [HZ_W-1:0] LIMIT      = HZ_W'(1) << (CNT_W - 1);
  localparam logic [HZ_W-1:0] OVH        = HZ_W'(OVERHEAD);
  localparam logic [HZ_W-1:0] RESET_HALF = half_period_of(HZ_W'(TIMER_HZ / DEFAULT_HZ), OVH);

  logic            accept;
  logic [HZ_W-1:0] corrected;
  logic            in_range;

  assign accept    = req_valid && !busy;
  assign div_start = accept && (req_hz != '0);
  assign corrected = half_period_of(div_quotient, OVH);
  assign in_range  = corrected < LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      status_valid <= 1'b0;
      status       <= RATE_OK;
      half_count   <= RESET_HALF[CNT_W-1:0];
    end else begin
      status_valid <= 1'b0;
      if (accept) begin
        if (req_hz == '0) begin
          status_valid <= 1'b1;
          status       <= RATE_ERR;
        end else begin
          busy <= 1'b1;
        end
      end else if (busy && div_fin) begin
        busy         <= 1'b0;
        status_valid <= 1'b1;
        if (in_range) begin
          half_count <= corrected[CNT_W-1:0];
          status     <= RATE_OK;
        end else begin
          status <= RATE_ERR;
        end
      end
    end
  end

endmodule

// File: rtl/tck_half_timer.sv
module tck_half_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wait_req,
  input  logic [CNT_W-1:0] half_count,
  output logic             tick,
  output logic             waiting
);
  logic [CNT_W-1:0] ctr_q;
  logic [CNT_W-1:0] target_q;

  // Signed difference test: the wait is over once now - target is not negative.
  function automatic logic reached(input logic [CNT_W-1:0] now, input logic [CNT_W-1:0] target);
    logic [CNT_W-1:0] d;
    d = now - target;
    return !d[CNT_W-1];
  endfunction

  assign tick = waiting ? reached(ctr_q, target_q)
                        : (wait_req && reached(ctr_q, ctr_q + half_count));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q    <= '0;
      target_q <= '0;
      waiting  <= 1'b0;
    end else begin
      ctr_q <= ctr_q + 1'b1;
      if (!waiting) begin
        if (wait_req && !tick) begin
          waiting  <= 1'b1;
          target_q <= ctr_q + half_count;
        end
      end else if (tick) begin
        waiting <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tck_rate_gen.sv
module tck_rate_gen
  import tck_rate_pkg::*;
#(
  parameter int unsigned TIMER_HZ   = 48_000_000,
  parameter int unsigned DEFAULT_HZ = 100_000,
  parameter int unsigned OVERHEAD   = 50,
  parameter int unsigned CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_req_valid,
  input  logic [31:0]      rate_req_hz,
  output logic             rate_busy,
  output logic             rate_status_valid,
  output logic [7:0]       rate_status,
  output logic [CNT_W-1:0] half_count,
  input  logic             wait_req,
  output logic             half_tick
);
  logic            div_start;
  logic            div_fin;
  logic [HZ_W-1:0] div_quotient;
  logic            timer_waiting;

  tck_rate_ctrl #(
    .TIMER_HZ  (TIMER_HZ),
    .DEFAULT_HZ(DEFAULT_HZ),
    .OVERHEAD  (OVERHEAD),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (rate_req_valid),
    .req_hz      (rate_req_hz),
    .div_fin     (div_fin),
    .div_quotient(div_quotient),
    .div_start   (div_start),
    .busy        (rate_busy),
    .status_valid(rate_status_valid),
    .status      (rate_status),
    .half_count  (half_count)
  );

  tck_rate_div #(.W(HZ_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (div_start),
    .dividend(HZ_W'(TIMER_HZ)),
    .divisor (rate_req_hz),
    .fin     (div_fin),
    .quotient(div_quotient)
  );

  tck_half_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_req  (wait_req),
    .half_count(half_count),
    .tick      (half_tick),
    .waiting   (timer_waiting)
  );

endmodule

// File: rtl/tck_rate_gen_chk.sv
module tck_rate_gen_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rate_req_valid,
  input logic [31:0]      rate_req_hz,
  input logic             rate_busy,
  input logic             rate_status_valid,
  input logic [7:0]       rate_status,
  input logic [CNT_W-1:0] half_count,
  input logic             wait_req,
  input logic             half_tick,
  input logic             waiting
);

  p_zero_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_req_valid && !rate_busy && rate_req_hz == 32'd0)
      |=> (rate_status_valid && rate_status == 8'hFF && !rate_busy && $stable(half_count)));

  p_status_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rate_status_valid |-> !rate_busy);

  p_status_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rate_status_valid |=> !rate_status_valid);

  p_status_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rate_status_valid |-> (rate_status == 8'h00 || rate_status == 8'hFF));

  p_refused_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_status_valid && rate_status == 8'hFF) |-> $stable(half_count));

  p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_status_valid && rate_status == 8'h00) |-> !half_count[CNT_W-1]);

  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rate_busy |=> ($stable(half_count) || rate_status_valid));

  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_busy && !rate_req_valid) |=> $stable(half_count));

  p_zero_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_req && !waiting && half_count == '0) |-> half_tick);

  p_pending_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !half_tick) |=> waiting);

endmodule

bind tck_rate_gen tck_rate_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .rate_req_valid   (rate_req_valid),
  .rate_req_hz      (rate_req_hz),
  .rate_busy        (rate_busy),
  .rate_status_valid(rate_status_valid),
  .rate_status      (rate_status),
  .half_count       (half_count),
  .wait_req         (wait_req),
  .half_tick        (half_tick),
  .waiting          (timer_waiting)
);

// File: tb/tck_rate_gen_test.sv
`timescale 1ns/1ps
module tck_rate_gen_test;
  localparam longint T_HZ   = 48_000_000;
  localparam longint DEF_HZ = 100_000;
  localparam longint OVH    = 50;
  localparam int     LAT    = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_req_valid = 1'b0;
  logic [31:0] rate_req_hz = '0;
  logic        rate_busy;
  logic        rate_status_valid;
  logic [7:0]  rate_status;
  logic [15:0] half_count;
  logic        wait_req = 1'b0;
  logic        half_tick;

  always #2.5 clk = ~clk;

  tck_rate_gen uut (
    .clk(clk), .rst_n(rst_n),
    .rate_req_valid(rate_req_valid), .rate_req_hz(rate_req_hz),
    .rate_busy(rate_busy), .rate_status_valid(rate_status_valid),
    .rate_status(rate_status), .half_count(half_count),
    .wait_req(wait_req), .half_tick(half_tick)
  );

  int    vectors = 0;
  int    misses = 0;
  string tag = "R1";

  // Behavioural reference from the requirements
  function automatic longint ref_half(longint hz);
    longint h;
    h = (T_HZ / hz) / 2;
    return (h <= OVH) ? 0 : h - OVH;
  endfunction

  bit     m_busy, m_sv, m_waiting, m_pend_ok;
  int     m_cnt, m_code, m_left;
  longint m_half, m_pend_half;

  function automatic bit model_tick();
    return m_waiting ? (m_left == 0) : (wait_req && m_half == 0);
  endfunction

  always @(posedge clk) begin
    bit t;
    if (!rst_n) begin
      m_busy = 0; m_sv = 0; m_waiting = 0; m_cnt = 0; m_code = 0; m_left = 0;
      m_half = ref_half(DEF_HZ);
    end else begin
      t = model_tick();
      if (m_waiting) begin
        if (t) m_waiting = 0; else m_left = m_left - 1;
      end else if (wait_req && !t) begin
        m_waiting = 1;
        m_left = int'(m_half) - 1;
      end
      m_sv = 0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 0; m_sv = 1;
          if (m_pend_ok) begin m_half = m_pend_half; m_code = 0; end
          else m_code = 255;
        end
      end else if (rate_req_valid) begin
        if (rate_req_hz == 0) begin
          m_sv = 1; m_code = 255;
        end else begin
          m_busy = 1; m_cnt = LAT;
          m_pend_half = ref_half(longint'(rate_req_hz));
          m_pend_ok = m_pend_half < 32768;
        end
      end
    end
  end

  task automatic cmp(string what, longint got, longint exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      cmp("rate_busy", rate_busy, m_busy);
      cmp("rate_status_valid", rate_status_valid, m_sv);
      if (m_sv) cmp("rate_status", rate_status, m_code);
      cmp("half_count", half_count, m_half);
      cmp("half_tick", half_tick, model_tick());
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(int unsigned hz);
    @(negedge clk);
    rate_req_valid = 1'b1;
    rate_req_hz = hz;
    @(negedge clk);
    rate_req_valid = 1'b0;
    rate_req_hz = '0;
  endtask

  task automatic start_wait(int hold);
    @(negedge clk);
    wait_req = 1'b1;
    repeat (hold) @(negedge clk);
    wait_req = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    misses++;
    $display("FAIL watchdog: run did not finish, got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; cycles(5);                         // reset setting 190, idle outputs
    tag = "R7"; start_wait(1); cycles(200);        // tick 190 cycles after start
    tag = "R8"; start_wait(1); cycles(20);
    start_wait(1); cycles(200);                    // second start during pending wait ignored
    tag = "R4"; request(100_000); cycles(40);      // 190
    request(400_000); cycles(40);                  // 60 -> 10
    request(470_588); cycles(40);                  // 51 -> 1
    request(480_000); cycles(40);                  // exactly 50 -> 0
    tag = "R7"; start_wait(3); cycles(5);          // zero setting: tick each requested cycle
    tag = "R2"; request(0); cycles(5);
    tag = "R5"; request(1); cycles(40);            // far out of range
    request(731); cycles(40);                      // 32781 just over limit
    tag = "R6"; request(200_000); cycles(5);       // 70 expected
    request(1_000_000); cycles(40);                // ignored while busy
    tag = "R3"; request(732); cycles(40);          // 32736 accepted
    tag = "R9";
    for (int i = 0; i < 3; i++) begin
      start_wait(1); cycles(32745);                // long waits across counter wrap
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule